// File: doc/BRIEF.md
# Interrupt Context Register Banking Unit

This unit keeps two program counters and two flag registers: one pair for normal execution and one for the interrupt handler. A single external interrupt request is accepted only at an instruction boundary, only when interrupts are enabled, and only when the machine is not already running the handler. When it is accepted, the unit switches to the handler pair. The handler program counter is reloaded with a fixed vector and the handler flags are cleared. A return strobe switches back to the normal pair. Nothing is saved to or restored from memory, and there is no stack. The normal pair simply stays untouched while the handler runs.

Program counter and flag writes always land in the pair that is active in the cycle of the write. The active program counter and flags are driven out combinationally from the selected pair. A condition evaluator turns the active flags into a branch-taken signal for a 3-bit condition selector. Flags are packed as N at bit 3, Z at bit 2, C at bit 1 and V at bit 0.

Top module: `irq_ctx_bank`

## Requirements
- R1: While reset is asserted, `inIrq` is 0, `activePc` equals the reset address `RESET_PC` (default 0) and `activeFlags` is 0.
- R2: At a clock edge where `instrBoundary`, `irqReq` and `irqEnable` are all 1 and `inIrq` is 0, the unit enters the interrupt. From the next cycle `inIrq` is 1, `activePc` equals `IRQ_VECTOR` (default 32'h0000_0080) and `activeFlags` is 0.
- R3: No interrupt is taken at an edge where `instrBoundary` is 0 or `irqEnable` is 0, whatever `irqReq` is.
- R4: While `inIrq` is 1, `irqReq` has no effect. `inIrq` stays 1 until an edge with `retStrobe` high.
- R5: An edge with `retStrobe` high while `inIrq` is 1 clears `inIrq`. The next cycle shows the normal PC and flags exactly as they stood after the interrupt was entered, including any write made in the entry cycle.
- R6: `retStrobe` has no effect while `inIrq` is 0.
- R7: When `pcWrEn` is 1, `pcWrData` is written into the PC of the pair that is active in that cycle, and it is visible on `activePc` in the next cycle. The other pair's PC is unchanged.
- R8: When `flagsWrEn` is 1, `flagsWrData` is written into the flags of the active pair, and it is visible on `activeFlags` in the next cycle. The other pair's flags are unchanged.
- R9: Every interrupt entry reloads the handler PC with `IRQ_VECTOR`, even if the handler overwrote its PC during an earlier interrupt.
- R10: `condTrue` is combinational from `condSel` and `activeFlags`. The codes are: 0 always, 1 Z, 2 not Z, 3 C, 4 N, 5 N xor V (signed less-than), 6 not C, 7 never.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqReq | input | 1 | External interrupt request (level) |
| irqEnable | input | 1 | Interrupt enable |
| instrBoundary | input | 1 | High in the last cycle of an instruction |
| retStrobe | input | 1 | Return from interrupt |
| pcWrEn | input | 1 | Write enable for the active PC |
| pcWrData | input | 32 | New PC value |
| flagsWrEn | input | 1 | Write enable for the active flags |
| flagsWrData | input | 4 | New flags {N,Z,C,V} |
| condSel | input | 3 | Condition code selector |
| activePc | output | 32 | PC of the active pair |
| activeFlags | output | 4 | Flags of the active pair |
| inIrq | output | 1 | High while the handler pair is active |
| condTrue | output | 1 | Selected condition holds on the active flags |

## Verification
The hardest case to reach from the ports is a write on the exact edge of a context switch. A PC or flags write in the entry cycle must land in the normal pair and then reappear after the return. A write in the return cycle must land in the handler pair and be lost on the next entry. The directed part of the bench builds both cases deliberately: it writes on the entry edge, writes from inside the handler, and returns with a write pending. After that, a long random phase holds `irqReq` high most of the time and pulses boundaries, returns and writes independently. This makes every collision of entry, return and write occur many times, and a behavioural model checks each one on every clock.

// File: rtl/irq_ctx_bank_pkg.sv
package irq_ctx_bank_pkg;
  localparam int FLAG_W = 4;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
  localparam int NUM_BANKS = 2;
  localparam int BANK_NORM = 0;
  localparam int BANK_IRQ = 1;

  typedef enum logic [2:0] {
    CC_ALWAYS = 3'd0,
    CC_ZERO   = 3'd1,
    CC_NZERO  = 3'd2,
    CC_CARRY  = 3'd3,
    CC_NEG    = 3'd4,
    CC_SLT    = 3'd5,
    CC_NCARRY = 3'd6,
    CC_NEVER  = 3'd7
  } condCode_e;

  typedef struct packed {
    logic                 enterIrq;
    logic                 leaveIrq;
    logic [NUM_BANKS-1:0] pcWr;
    logic [NUM_BANKS-1:0] flagsWr;
  } bankStrobes_t;
endpackage

// File: rtl/irq_ctx_bank_ctrl.sv
module irq_ctx_bank_ctrl
  import irq_ctx_bank_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         irqReq,
  input  logic         irqEnable,
  input  logic         instrBoundary,
  input  logic         retStrobe,
  input  logic         pcWrEn,
  input  logic         flagsWrEn,
  output bankStrobes_t strobes,
  output logic         inIrq
);
  logic inIrqQ;

  always_comb begin
    strobes = '0;
    strobes.enterIrq = instrBoundary & irqReq & irqEnable & ~inIrqQ;
    strobes.leaveIrq = retStrobe & inIrqQ;
    strobes.pcWr[BANK_NORM] = pcWrEn & ~inIrqQ;
    strobes.pcWr[BANK_IRQ] = pcWrEn & inIrqQ;
    strobes.flagsWr[BANK_NORM] = flagsWrEn & ~inIrqQ;
    strobes.flagsWr[BANK_IRQ] = flagsWrEn & inIrqQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inIrqQ <= 1'b0;
    end else if (strobes.enterIrq) begin
      inIrqQ <= 1'b1;
    end else if (strobes.leaveIrq) begin
      inIrqQ <= 1'b0;
    end
  end

  assign inIrq = inIrqQ;
endmodule

// File: rtl/irq_ctx_bank_dp.sv
module irq_ctx_bank_dp
  import irq_ctx_bank_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] RESET_PC   = '0,
  parameter logic [PC_W-1:0] IRQ_VECTOR = 'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobes_t      strobes,
  input  logic              inIrq,
  input  logic [PC_W-1:0]   pcWrData,
  input  logic [FLAG_W-1:0] flagsWrData,
  output logic [PC_W-1:0]   activePc,
  output logic [FLAG_W-1:0] activeFlags
);
  logic [PC_W-1:0]   pcBank    [NUM_BANKS];
  logic [FLAG_W-1:0] flagsBank [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [PC_W-1:0] INIT_PC = (b == BANK_IRQ) ? IRQ_VECTOR : RESET_PC;
    logic reload;
    if (b == BANK_IRQ) begin : g_reload
      assign reload = strobes.enterIrq;
    end else begin : g_noreload
      assign reload = 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pcBank[b]    <= INIT_PC;
        flagsBank[b] <= '0;
      end else if (reload) begin
        pcBank[b]    <= IRQ_VECTOR;
        flagsBank[b] <= '0;
      end else begin
        if (strobes.pcWr[b])    pcBank[b]    <= pcWrData;
        if (strobes.flagsWr[b]) flagsBank[b] <= flagsWrData;
      end
    end
  end

  always_comb begin
    activePc    = inIrq ? pcBank[BANK_IRQ]    : pcBank[BANK_NORM];
    activeFlags = inIrq ? flagsBank[BANK_IRQ] : flagsBank[BANK_NORM];
  end
endmodule

// File: rtl/irq_ctx_cond.sv
module irq_ctx_cond
  import irq_ctx_bank_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic [2:0]        condSel,
  output logic              condTrue
);
  always_comb begin
    unique case (condCode_e'(condSel))
      CC_ALWAYS: condTrue = 1'b1;
      CC_ZERO:   condTrue = flags[FLAG_Z];
      CC_NZERO:  condTrue = ~flags[FLAG_Z];
      CC_CARRY:  condTrue = flags[FLAG_C];
      CC_NEG:    condTrue = flags[FLAG_N];
      CC_SLT:    condTrue = flags[FLAG_N] ^ flags[FLAG_V];
      CC_NCARRY: condTrue = ~flags[FLAG_C];
      default:   condTrue = 1'b0;
    endcase
  end
endmodule

// File: rtl/irq_ctx_bank.sv
module irq_ctx_bank
  import irq_ctx_bank_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] RESET_PC   = '0,
  parameter logic [PC_W-1:0] IRQ_VECTOR = 'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqReq,
  input  logic              irqEnable,
  input  logic              instrBoundary,
  input  logic              retStrobe,
  input  logic              pcWrEn,
  input  logic [PC_W-1:0]   pcWrData,
  input  logic              flagsWrEn,
  input  logic [FLAG_W-1:0] flagsWrData,
  input  logic [2:0]        condSel,
  output logic [PC_W-1:0]   activePc,
  output logic [FLAG_W-1:0] activeFlags,
  output logic              inIrq,
  output logic              condTrue
);
  bankStrobes_t strobes;

  irq_ctx_bank_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqEnable(irqEnable),
    .instrBoundary(instrBoundary), .retStrobe(retStrobe),
    .pcWrEn(pcWrEn), .flagsWrEn(flagsWrEn),
    .strobes(strobes), .inIrq(inIrq)
  );

  irq_ctx_bank_dp #(.PC_W(PC_W), .RESET_PC(RESET_PC), .IRQ_VECTOR(IRQ_VECTOR)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inIrq(inIrq),
    .pcWrData(pcWrData), .flagsWrData(flagsWrData),
    .activePc(activePc), .activeFlags(activeFlags)
  );

  irq_ctx_cond i_cond (
    .flags(activeFlags), .condSel(condSel), .condTrue(condTrue)
  );
endmodule

// File: rtl/irq_ctx_bank_chk.sv
module irq_ctx_bank_chk
  import irq_ctx_bank_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter logic [PC_W-1:0] RESET_PC   = '0,
  parameter logic [PC_W-1:0] IRQ_VECTOR = 'h80
) (
  input logic              clk,
  input logic              rstN,
  input logic              irqReq,
  input logic              irqEnable,
  input logic              instrBoundary,
  input logic              retStrobe,
  input logic              pcWrEn,
  input logic [PC_W-1:0]   pcWrData,
  input logic              flagsWrEn,
  input logic [FLAG_W-1:0] flagsWrData,
  input logic [2:0]        condSel,
  input logic [PC_W-1:0]   activePc,
  input logic [FLAG_W-1:0] activeFlags,
  input logic              inIrq,
  input logic              condTrue
);
  logic              takeNow;
  logic [PC_W-1:0]   savedPc;
  logic [FLAG_W-1:0] savedFlags;

  assign takeNow = instrBoundary && irqReq && irqEnable && !inIrq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      savedPc    <= RESET_PC;
      savedFlags <= '0;
    end else if (takeNow) begin
      savedPc    <= pcWrEn ? pcWrData : activePc;
      savedFlags <= flagsWrEn ? flagsWrData : activeFlags;
    end
  end

  always_comb begin
    if (!rstN) begin
      assert_reset_state_R1: assert (!inIrq && activePc == RESET_PC && activeFlags == '0);
    end
  end

  assert_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    takeNow |=> (inIrq && activePc == IRQ_VECTOR && activeFlags == '0));

  assert_no_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!inIrq && (!instrBoundary || !irqEnable)) |=> !inIrq);

  assert_no_nesting_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inIrq && !retStrobe) |=> inIrq);

  assert_leave_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inIrq && retStrobe) |=> !inIrq);

  assert_resume_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inIrq) |-> (activePc == savedPc && activeFlags == savedFlags));

  assert_pc_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pcWrEn && !takeNow && !(inIrq && retStrobe)) |=> activePc == $past(pcWrData));

  assert_flags_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (flagsWrEn && !takeNow && !(inIrq && retStrobe)) |=> activeFlags == $past(flagsWrData));

  assert_cond_always_R10: assert property (@(posedge clk) disable iff (!rstN)
    (condSel == 3'd0) |-> condTrue);

  assert_cond_never_R10: assert property (@(posedge clk) disable iff (!rstN)
    (condSel == 3'd7) |-> !condTrue);
endmodule

bind irq_ctx_bank irq_ctx_bank_chk #(.PC_W(PC_W), .RESET_PC(RESET_PC), .IRQ_VECTOR(IRQ_VECTOR)) i_chk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqEnable(irqEnable),
  .instrBoundary(instrBoundary), .retStrobe(retStrobe),
  .pcWrEn(pcWrEn), .pcWrData(pcWrData), .flagsWrEn(flagsWrEn),
  .flagsWrData(flagsWrData), .condSel(condSel), .activePc(activePc),
  .activeFlags(activeFlags), .inIrq(inIrq), .condTrue(condTrue)
);

// File: tb/test_irq_ctx_bank.sv
`timescale 1ns/1ps
module test_irq_ctx_bank;
  localparam logic [31:0] VEC = 32'h0000_0080;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irqReq = 0, irqEnable = 0, instrBoundary = 0, retStrobe = 0;
  logic        pcWrEn = 0, flagsWrEn = 0;
  logic [31:0] pcWrData = '0;
  logic [3:0]  flagsWrData = '0;
  logic [2:0]  condSel = '0;
  logic [31:0] activePc;
  logic [3:0]  activeFlags;
  logic        inIrq, condTrue;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string curTag = "R1";

  logic [31:0] mPc [2];
  logic [3:0]  mFlags [2];
  logic        mIn;

  irq_ctx_bank i_irq_ctx_bank (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqEnable(irqEnable),
    .instrBoundary(instrBoundary), .retStrobe(retStrobe),
    .pcWrEn(pcWrEn), .pcWrData(pcWrData), .flagsWrEn(flagsWrEn),
    .flagsWrData(flagsWrData), .condSel(condSel), .activePc(activePc),
    .activeFlags(activeFlags), .inIrq(inIrq), .condTrue(condTrue)
  );

  always #4 clk = ~clk;

  function automatic logic expCond(input logic [2:0] sel, input logic [3:0] f);
    case (sel)
      3'd0: return 1'b1;
      3'd1: return f[2];
      3'd2: return !f[2];
      3'd3: return f[1];
      3'd4: return f[3];
      3'd5: return f[3] ^ f[0];
      3'd6: return !f[1];
      default: return 1'b0;
    endcase
  endfunction

  // Behavioural reference: two banks, one context bit
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPc[0] = 32'h0; mPc[1] = VEC; mFlags[0] = 4'h0; mFlags[1] = 4'h0; mIn = 1'b0;
    end else begin
      automatic bit take = instrBoundary && irqReq && irqEnable && !mIn;
      automatic bit leave = retStrobe && mIn;
      automatic int bank = mIn ? 1 : 0;
      if (pcWrEn) mPc[bank] = pcWrData;
      if (flagsWrEn) mFlags[bank] = flagsWrData;
      if (take) begin mIn = 1'b1; mPc[1] = VEC; mFlags[1] = 4'h0; end
      if (leave) mIn = 1'b0;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Compare against the model on every falling edge
  always @(negedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cycles);
      finishRun();
    end
    if (rstN) begin
      automatic int bank = mIn ? 1 : 0;
      check({curTag, " inIrq"}, 64'(inIrq), 64'(mIn));
      check({curTag, " activePc"}, 64'(activePc), 64'(mPc[bank]));
      check({curTag, " activeFlags"}, 64'(activeFlags), 64'(mFlags[bank]));
      check("R10 condTrue", 64'(condTrue), 64'(expCond(condSel, mFlags[bank])));
    end
  end

  task automatic drive(input logic b, input logic req, input logic en, input logic ret,
                       input logic pw, input logic [31:0] pd, input logic fw,
                       input logic [3:0] fd, input logic [2:0] cs);
    @(negedge clk); #1;
    instrBoundary = b; irqReq = req; irqEnable = en; retStrobe = ret;
    pcWrEn = pw; pcWrData = pd; flagsWrEn = fw; flagsWrData = fd; condSel = cs;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 32'h0, 0, 4'h0, 3'd0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1 inIrq", 64'(inIrq), 64'(0));
    check("R1 activePc", 64'(activePc), 64'(0));
    check("R1 activeFlags", 64'(activeFlags), 64'(0));
    #1 rstN = 1'b1;

    curTag = "R7";
    drive(0, 0, 0, 0, 1, 32'h100, 1, 4'b0100, 3'd1);
    idle();
    check("R7 pc written", 64'(activePc), 64'(32'h100));
    check("R8 flags written", 64'(activeFlags), 64'(4'b0100));

    curTag = "R3";
    drive(1, 1, 0, 0, 0, 0, 0, 0, 3'd2);
    drive(0, 1, 1, 0, 0, 0, 0, 0, 3'd2);
    drive(0, 1, 1, 0, 0, 0, 0, 0, 3'd2);
    idle();
    check("R3 no entry", 64'(inIrq), 64'(0));

    curTag = "R2";
    drive(1, 1, 1, 0, 1, 32'h104, 1, 4'b1000, 3'd4);
    idle();
    check("R2 inIrq", 64'(inIrq), 64'(1));
    check("R2 vector", 64'(activePc), 64'(VEC));
    check("R2 flags clear", 64'(activeFlags), 64'(0));

    curTag = "R4";
    drive(1, 1, 1, 0, 1, 32'h2000, 1, 4'b1111, 3'd5);
    drive(1, 1, 1, 0, 0, 0, 0, 0, 3'd3);
    idle();
    check("R4 stays in irq", 64'(inIrq), 64'(1));
    check("R8 handler flags", 64'(activeFlags), 64'(4'b1111));

    curTag = "R5";
    drive(0, 0, 0, 1, 1, 32'h3000, 0, 0, 3'd0);
    idle();
    check("R5 left irq", 64'(inIrq), 64'(0));
    check("R5 normal pc", 64'(activePc), 64'(32'h104));
    check("R5 normal flags", 64'(activeFlags), 64'(4'b1000));

    curTag = "R6";
    drive(0, 0, 1, 1, 0, 0, 0, 0, 3'd0);
    idle();
    check("R6 ret ignored", 64'(inIrq), 64'(0));
    check("R6 pc kept", 64'(activePc), 64'(32'h104));

    curTag = "R9";
    drive(1, 1, 1, 0, 0, 0, 0, 0, 3'd0);
    idle();
    check("R9 vector reloaded", 64'(activePc), 64'(VEC));
    drive(0, 0, 0, 1, 0, 0, 0, 0, 3'd0);

    curTag = "R10";
    for (int f = 0; f < 16; f++) begin
      drive(0, 0, 0, 0, 0, 0, 1, 4'(f), 3'd0);
      for (int s = 0; s < 8; s++) drive(0, 0, 0, 0, 0, 0, 0, 0, 3'(s));
    end

    curTag = "R7 random";
    for (int i = 0; i < 4000; i++) begin
      drive(($urandom % 3) == 0, ($urandom % 4) != 0, ($urandom % 5) != 0,
            ($urandom % 6) == 0, ($urandom % 2) == 0, $urandom,
            ($urandom % 2) == 0, 4'($urandom), 3'($urandom));
    end
    idle();
    @(negedge clk); #1;
    finishRun();
  end
endmodule